// File: doc/BRIEF.md
# Multi-Channel Descriptor Command Sequencer

This block is a command engine with four channels, programmed through registers. Software gives a channel the address of a descriptor in memory by writing the channel's command pointer. It then adds work by writing a count into the channel's semaphore register. When a channel is enabled, armed, has a non-zero pending count and carries no error, it competes for the single sequencer. Channels that are ready at the same time are served round-robin.

The sequencer reads the eight-word descriptor through a 32-bit memory port, with one read outstanding at a time. It hands the operation fields to a downstream operation unit with a start/done handshake. It then writes a status word back into the descriptor. Finally it updates the channel: the pending count, the interrupt flag, the chaining pointer, or the error status. Descriptors link through their first word, so one channel can walk a list while its count stays non-zero.

The sequencer is a six-state machine. S_IDLE goes to S_FETCH when any channel is ready. S_FETCH loops once per word. After word 7 it goes to S_LAUNCH if the descriptor enables the cipher or the hash, and to S_WRBACK otherwise. S_LAUNCH always goes to S_WAIT_OP. S_WAIT_OP goes to S_WRBACK on op_done. S_WRBACK goes to S_FINISH when the write is acknowledged. S_FINISH always returns to S_IDLE.

Top module: `cseq_engine`

## Requirements
- R1: After reset, every register reads zero, irq is low, and mem_req and op_start are low.
- R2: The register map is as follows.
  - The channel-enable mask is at 0x20 and keeps only bits 3:0.
  - Channel n's registers sit at base 0x100 + n*0x40: command pointer at +0x00 (read/write), pending count at +0x10, error status at +0x20, and status clear at +0x28.
  - Writing the command pointer arms the channel.
- R3: A write to a channel's pending-count register adds the written value to the count. The count saturates at 255.
- R4: A descriptor fetch reads eight words at pointer + 4*i, for i = 0 to 7 in ascending order. Each request holds its address until mem_ack, and only one request is outstanding at a time.
- R5: The descriptor words map to the operation port as follows.
  - Word 1 goes to op_ctrl0, word 2 to op_ctrl1, word 3 to op_src, word 4 to op_dst, word 5 to op_size and word 6 to op_payload.
  - op_start is a one-cycle pulse, and the sequencer then waits for op_done.
  - A descriptor with ctrl0 bits 5 (cipher) and 6 (hash) both clear never pulses op_start.
- R6: After the operation, the sequencer writes the status word to pointer + 28: zero on success, the error code on failure. The channel's interrupt flag rises only after that write is acknowledged.
- R7: On completion, ctrl0 bit 1 decrements the pending count and ctrl0 bit 0 sets global status bit n at 0x10. irq is the OR of the global status bits.
- R8: Writing a mask to 0x18 clears the matching global status bits.
- R9: On success, a non-zero word 0 becomes the new command pointer, and the channel keeps running while its count is non-zero. A zero word 0 disarms the channel and leaves the pointer unchanged.
- R10: On op_err, the channel handles the failure as follows.
  - The channel's status bits 7:0 take op_code, or 0x01 if op_code is zero.
  - The count is not decremented.
  - The channel fetches nothing more until that status is cleared through +0x28.
- R11: A channel whose enable bit is clear is never granted, whatever its count.
- R12: Among ready channels, the grant goes to the first one after the channel granted last, in ascending circular order. The search starts at channel 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data (status word) |
| mem_ack | input | 1 | Memory request accepted; read data valid |
| mem_rdata | input | 32 | Memory read data |
| op_start | output | 1 | One-cycle operation start |
| op_ctrl0 | output | 32 | Descriptor control word 0 |
| op_ctrl1 | output | 32 | Descriptor control word 1 |
| op_src | output | 32 | Source address |
| op_dst | output | 32 | Destination address |
| op_size | output | 32 | Byte count |
| op_payload | output | 32 | Payload address |
| op_done | input | 1 | Operation finished |
| op_err | input | 1 | Operation failed (valid with op_done) |
| op_code | input | 8 | Error code (valid with op_done) |
| irq | output | 1 | OR of the global status bits |

## Verification
Some rules are checked on every clock. These cover the memory-request hold, the single-cycle op_start, the one-hot grant, the rule that no disabled or errored channel is granted, and the ordering of the status write before an interrupt flag. They also cover the rule that irq falls only after a write to the clear register.

Other rules only the bench scenarios can show, because they depend on memory contents and counting. These include the word order of a fetch and the status value written back. They also include the arithmetic of the count, chain following and disarming, recovery from an error stall, and the round-robin order after a known previous grant.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LAUNCH,
        S_WAIT_OP,
        S_WRBACK,
        S_FINISH
    } seq_state_t;

    localparam int DESC_WORDS   = 8;
    localparam int STATUS_WORD  = 7;

    localparam int REG_GSTAT    = 'h010;
    localparam int REG_GCLR     = 'h018;
    localparam int REG_CHEN     = 'h020;
    localparam int CH_BASE      = 'h100;
    localparam int CH_STRIDE    = 'h040;
    localparam int CH_PTR       = 'h000;
    localparam int CH_SEMA      = 'h010;
    localparam int CH_STAT      = 'h020;
    localparam int CH_SCLR      = 'h028;

    localparam int C0_IRQ       = 0;
    localparam int C0_DEC       = 1;
    localparam int C0_CIPHER    = 5;
    localparam int C0_HASH      = 6;

endpackage

// File: rtl/cseq_rr_arb.sv
module cseq_rr_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx,
    output logic          any
);

    logic [IW-1:0] last_q;

    always_comb begin
        any       = 1'b0;
        grant_idx = '0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last_q) + k) % N;
            if (!any && req[c]) begin
                any       = 1'b1;
                grant_idx = IW'(c);
            end
        end
        grant = '0;
        if (any) grant[grant_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             last_q <= IW'(N - 1);
        else if (take && any)   last_q <= grant_idx;
    end

endmodule

// File: rtl/cseq_chan.sv
module cseq_chan #(
    parameter int AW     = 32,
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_ptr,
    input  logic              wr_sema,
    input  logic              wr_clr,
    input  logic [31:0]       wdata,
    input  logic              fin_ok,
    input  logic              fin_bad,
    input  logic [7:0]        fin_code,
    input  logic              fin_dec,
    input  logic [AW-1:0]     fin_next,
    output logic [AW-1:0]     cmdptr,
    output logic [SEMA_W-1:0] sema,
    output logic [7:0]        stat,
    output logic              ready
);

    localparam logic [32:0] SEMA_MAX = 33'((1 << SEMA_W) - 1);

    logic              armed_q;
    logic [SEMA_W-1:0] after_dec;
    logic [32:0]       total;
    logic [SEMA_W-1:0] sema_d;

    always_comb begin
        after_dec = sema;
        if (fin_ok && fin_dec && sema != '0) after_dec = sema - 1'b1;
        total  = 33'(after_dec) + (wr_sema ? 33'(wdata) : 33'd0);
        sema_d = (total > SEMA_MAX) ? SEMA_MAX[SEMA_W-1:0] : total[SEMA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmdptr  <= '0;
            armed_q <= 1'b0;
            sema    <= '0;
            stat    <= '0;
        end else begin
            sema <= sema_d;
            if (fin_ok) begin
                if (fin_next != '0) cmdptr  <= fin_next;
                else                armed_q <= 1'b0;
            end
            if (wr_ptr) begin
                cmdptr  <= wdata[AW-1:0];
                armed_q <= 1'b1;
            end
            if (fin_bad)     stat <= fin_code;
            else if (wr_clr) stat <= stat & ~wdata[7:0];
        end
    end

    assign ready = en && armed_q && (sema != '0) && (stat == '0);

endmodule

// File: rtl/cseq_fsm.sv
module cseq_fsm
    import cseq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_any,
    input  logic [CH_W-1:0] grant_idx,
    input  logic [AW-1:0]   grant_ptr,
    output logic            take,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic            mem_ack,
    input  logic [31:0]     mem_rdata,
    output logic            op_start,
    output logic [31:0]     op_ctrl0,
    output logic [31:0]     op_ctrl1,
    output logic [31:0]     op_src,
    output logic [31:0]     op_dst,
    output logic [31:0]     op_size,
    output logic [31:0]     op_payload,
    input  logic            op_done,
    input  logic            op_err,
    input  logic [7:0]      op_code,
    output logic            fin_valid,
    output logic [CH_W-1:0] fin_ch,
    output logic            fin_err,
    output logic [7:0]      fin_code,
    output logic            fin_dec,
    output logic            fin_irq,
    output logic [AW-1:0]   fin_next
);

    localparam int IDX_W = $clog2(DESC_WORDS);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [AW-1:0]    base_q;
    logic [CH_W-1:0]  ch_q;
    logic [31:0]      words_q [STATUS_WORD];
    logic             err_q;
    logic [7:0]       code_q;
    logic             op_used;

    assign op_used = words_q[1][C0_CIPHER] || words_q[1][C0_HASH];

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_any) state_d = S_FETCH;
            S_FETCH:   if (mem_ack && idx_q == IDX_W'(STATUS_WORD))
                           state_d = op_used ? S_LAUNCH : S_WRBACK;
            S_LAUNCH:  state_d = S_WAIT_OP;
            S_WAIT_OP: if (op_done) state_d = S_WRBACK;
            S_WRBACK:  if (mem_ack) state_d = S_FINISH;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // descriptor capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            base_q <= '0;
            ch_q   <= '0;
            err_q  <= 1'b0;
            code_q <= '0;
            for (int w = 0; w < STATUS_WORD; w++) words_q[w] <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_any) begin
                    base_q <= grant_ptr;
                    ch_q   <= grant_idx;
                    idx_q  <= '0;
                    err_q  <= 1'b0;
                    code_q <= '0;
                end
                S_FETCH: if (mem_ack) begin
                    if (idx_q != IDX_W'(STATUS_WORD)) words_q[idx_q] <= mem_rdata;
                    idx_q <= idx_q + 1'b1;
                end
                S_WAIT_OP: if (op_done && op_err) begin
                    err_q  <= 1'b1;
                    code_q <= (op_code == 8'h00) ? 8'h01 : op_code;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        take      = (state_q == S_IDLE) && req_any;
        mem_req   = (state_q == S_FETCH) || (state_q == S_WRBACK);
        mem_we    = (state_q == S_WRBACK);
        mem_addr  = base_q + ((state_q == S_WRBACK) ? AW'(4 * STATUS_WORD)
                                                    : AW'({idx_q, 2'b00}));
        mem_wdata = {24'h0, code_q};
        op_start  = (state_q == S_LAUNCH);
        fin_valid = (state_q == S_FINISH);
    end

    assign op_ctrl0   = words_q[1];
    assign op_ctrl1   = words_q[2];
    assign op_src     = words_q[3];
    assign op_dst     = words_q[4];
    assign op_size    = words_q[5];
    assign op_payload = words_q[6];
    assign fin_ch     = ch_q;
    assign fin_err    = err_q;
    assign fin_code   = code_q;
    assign fin_dec    = words_q[1][C0_DEC];
    assign fin_irq    = words_q[1][C0_IRQ];
    assign fin_next   = words_q[0][AW-1:0];

endmodule

// File: rtl/cseq_engine.sv
module cseq_engine
    import cseq_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int AW     = 32,
    parameter int SEMA_W = 8,
    parameter int REG_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              op_start,
    output logic [31:0]       op_ctrl0,
    output logic [31:0]       op_ctrl1,
    output logic [31:0]       op_src,
    output logic [31:0]       op_dst,
    output logic [31:0]       op_size,
    output logic [31:0]       op_payload,
    input  logic              op_done,
    input  logic              op_err,
    input  logic [7:0]        op_code,
    output logic              irq
);

    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic [N_CH-1:0]   en_q;
    logic [N_CH-1:0]   gstat_q;
    logic [N_CH-1:0]   ch_ready;
    logic [N_CH-1:0]   ch_err_vec;
    logic [N_CH-1:0]   arb_grant;
    logic [CH_W-1:0]   grant_idx;
    logic              arb_any;
    logic              take;
    logic [AW-1:0]     ch_ptr  [N_CH];
    logic [SEMA_W-1:0] ch_sema [N_CH];
    logic [7:0]        ch_stat [N_CH];

    logic              fin_valid, fin_err, fin_dec, fin_irq;
    logic [CH_W-1:0]   fin_ch;
    logic [7:0]        fin_code;
    logic [AW-1:0]     fin_next;

    cseq_rr_arb #(.N(N_CH), .IW(CH_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(ch_ready), .take(take),
        .grant(arb_grant), .grant_idx(grant_idx), .any(arb_any)
    );

    for (genvar n = 0; n < N_CH; n++) begin : g_ch
        localparam int B = CH_BASE + n * CH_STRIDE;
        logic sel_ok, sel_bad;
        assign sel_ok  = fin_valid && (fin_ch == CH_W'(n)) && !fin_err;
        assign sel_bad = fin_valid && (fin_ch == CH_W'(n)) && fin_err;

        cseq_chan #(.AW(AW), .SEMA_W(SEMA_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .en(en_q[n]),
            .wr_ptr (reg_wr && reg_addr == REG_AW'(B + CH_PTR)),
            .wr_sema(reg_wr && reg_addr == REG_AW'(B + CH_SEMA)),
            .wr_clr (reg_wr && reg_addr == REG_AW'(B + CH_SCLR)),
            .wdata(reg_wdata),
            .fin_ok(sel_ok), .fin_bad(sel_bad), .fin_code(fin_code),
            .fin_dec(fin_dec), .fin_next(fin_next),
            .cmdptr(ch_ptr[n]), .sema(ch_sema[n]), .stat(ch_stat[n]),
            .ready(ch_ready[n])
        );
        assign ch_err_vec[n] = (ch_stat[n] != 8'h00);
    end

    cseq_fsm #(.AW(AW), .CH_W(CH_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_any(arb_any), .grant_idx(grant_idx), .grant_ptr(ch_ptr[grant_idx]),
        .take(take),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .op_start(op_start), .op_ctrl0(op_ctrl0), .op_ctrl1(op_ctrl1),
        .op_src(op_src), .op_dst(op_dst), .op_size(op_size),
        .op_payload(op_payload), .op_done(op_done), .op_err(op_err),
        .op_code(op_code),
        .fin_valid(fin_valid), .fin_ch(fin_ch), .fin_err(fin_err),
        .fin_code(fin_code), .fin_dec(fin_dec), .fin_irq(fin_irq),
        .fin_next(fin_next)
    );

    // global registers: set from completion wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            gstat_q <= '0;
        end else begin
            if (reg_wr && reg_addr == REG_AW'(REG_CHEN))
                en_q <= reg_wdata[N_CH-1:0];
            gstat_q <= (gstat_q & ~((reg_wr && reg_addr == REG_AW'(REG_GCLR))
                                    ? reg_wdata[N_CH-1:0] : '0))
                     | ((fin_valid && fin_irq) ? (N_CH'(1) << fin_ch) : '0);
        end
    end

    assign irq = |gstat_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(REG_GSTAT)) reg_rdata = 32'(gstat_q);
        if (reg_addr == REG_AW'(REG_CHEN))  reg_rdata = 32'(en_q);
        for (int n = 0; n < N_CH; n++) begin
            if (reg_addr == REG_AW'(CH_BASE + n * CH_STRIDE + CH_PTR))  reg_rdata = 32'(ch_ptr[n]);
            if (reg_addr == REG_AW'(CH_BASE + n * CH_STRIDE + CH_SEMA)) reg_rdata = 32'(ch_sema[n]);
            if (reg_addr == REG_AW'(CH_BASE + n * CH_STRIDE + CH_STAT)) reg_rdata = 32'(ch_stat[n]);
        end
    end

endmodule

// File: rtl/cseq_checker.sv
module cseq_checker
    import cseq_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int AW     = 32,
    parameter int REG_AW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic              mem_req,
    input logic              mem_we,
    input logic [AW-1:0]     mem_addr,
    input logic              mem_ack,
    input logic              op_start,
    input logic              irq,
    input logic [N_CH-1:0]   arb_grant,
    input logic [N_CH-1:0]   en_mask,
    input logic [N_CH-1:0]   err_vec
);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    p_flag_after_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_req && mem_we && mem_ack, 2));

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr && reg_addr == REG_AW'(REG_GCLR)));

    p_err_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_grant & err_vec) == '0);

    p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_grant & ~en_mask) == '0);

    p_grant_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arb_grant));

endmodule

bind cseq_engine cseq_checker #(.N_CH(N_CH), .AW(AW), .REG_AW(REG_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .op_start(op_start), .irq(irq), .arb_grant(arb_grant), .en_mask(en_q),
    .err_vec(ch_err_vec)
);

// File: tb/test_cseq_engine.sv
`timescale 1ns/1ps
module test_cseq_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        op_start, op_done, op_err;
    logic [7:0]  op_code;
    logic [31:0] op_ctrl0, op_ctrl1, op_src, op_dst, op_size, op_payload;
    logic        irq;

    always #2 clk = ~clk;

    cseq_engine i_cseq_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .op_start(op_start), .op_ctrl0(op_ctrl0), .op_ctrl1(op_ctrl1),
        .op_src(op_src), .op_dst(op_dst), .op_size(op_size),
        .op_payload(op_payload), .op_done(op_done), .op_err(op_err),
        .op_code(op_code), .irq(irq)
    );

    int n_chk = 0;
    int n_err = 0;

    // behavioural memory, operation stub, activity logs
    logic [31:0] mem [0:255];
    logic [31:0] fetch_q[$];
    logic [31:0] op_src_q[$];
    logic [31:0] op_c0_q[$];
    logic [31:0] last_c1, last_dst, last_size, last_pay;
    int          op_count = 0;
    int          op_cnt_dn = 0;
    logic        stub_err = 1'b0;
    logic [7:0]  stub_code = 8'h00;

    initial begin
        mem_ack = 1'b0; mem_rdata = '0;
        op_done = 1'b0; op_err = 1'b0; op_code = '0;
    end

    always @(posedge clk) begin
        mem_ack   <= mem_req && !mem_ack;
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_req && mem_ack && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_req && mem_ack && !mem_we) fetch_q.push_back(mem_addr);
        op_done <= 1'b0;
        if (op_start) begin
            op_count  <= op_count + 1;
            op_src_q.push_back(op_src);
            op_c0_q.push_back(op_ctrl0);
            last_c1 <= op_ctrl1; last_dst <= op_dst;
            last_size <= op_size; last_pay <= op_payload;
            op_cnt_dn <= 3;
        end else if (op_cnt_dn > 0) begin
            op_cnt_dn <= op_cnt_dn - 1;
            if (op_cnt_dn == 1) begin
                op_done <= 1'b1;
                op_err  <= stub_err;
                op_code <= stub_code;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, req, act, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    function automatic logic [11:0] cha(input int n, input int off);
        return 12'(32'h100 + n * 32'h40 + off);
    endfunction

    task automatic put_desc(input int a, input logic [31:0] nxt, input logic [31:0] c0,
                            input logic [31:0] c1, input logic [31:0] src, input logic [31:0] st);
        mem[(a >> 2) + 0] = nxt;
        mem[(a >> 2) + 1] = c0;
        mem[(a >> 2) + 2] = c1;
        mem[(a >> 2) + 3] = src;
        mem[(a >> 2) + 4] = 32'h2222;
        mem[(a >> 2) + 5] = 32'h40;
        mem[(a >> 2) + 6] = 32'h3333;
        mem[(a >> 2) + 7] = st;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int ops0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd(12'h010, d); chk_eq("R1 gstat", d, 0);
        rd(12'h020, d); chk_eq("R1 enable", d, 0);
        rd(cha(2, 'h0), d); chk_eq("R1 cmdptr", d, 0);
        rd(cha(1, 'h10), d); chk_eq("R1 count", d, 0);
        chk_eq("R1 outputs", {29'd0, irq, mem_req, op_start}, 0);

        // R2: register map and enable width
        wr(12'h020, 32'hFF);
        rd(12'h020, d); chk_eq("R2 enable keeps 3:0", d, 32'hF);
        wr(cha(3, 'h0), 32'h0000_0123);
        rd(cha(3, 'h0), d); chk_eq("R2 cmdptr readback", d, 32'h123);
        wr(12'h020, 32'h0);

        // R3: count adds and saturates
        wr(cha(3, 'h10), 32'd200);
        wr(cha(3, 'h10), 32'd100);
        rd(cha(3, 'h10), d); chk_eq("R3 saturate", d, 32'd255);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        wr(12'h020, 32'hF);

        // R4 R5 R6 R7: single descriptor on channel 0
        put_desc('h40, 0, 32'h323, 32'h10, 32'h1111, 32'hDEAD);
        fetch_q.delete(); op_src_q.delete(); op_c0_q.delete();
        wr(cha(0, 'h0), 32'h40);
        wr(cha(0, 'h10), 32'd1);
        repeat (100) @(posedge clk);
        chk_eq("R4 fetch count", fetch_q.size(), 8);
        for (int i = 0; i < 8; i++)
            if (i < fetch_q.size()) chk_eq("R4 fetch order", fetch_q[i], 32'h40 + 4 * i);
        chk_eq("R5 op count", op_count, 1);
        chk_eq("R5 ctrl0", op_c0_q.size() > 0 ? op_c0_q[0] : 32'hX, 32'h323);
        chk_eq("R5 src", op_src_q.size() > 0 ? op_src_q[0] : 32'hX, 32'h1111);
        chk_eq("R5 ctrl1", last_c1, 32'h10);
        chk_eq("R5 dst/size/pay", {last_dst[15:0], last_size[7:0], last_pay[7:0]}, {16'h2222, 8'h40, 8'h33});
        chk_eq("R6 status written", mem['h5C >> 2], 32'h0);
        rd(12'h010, d); chk_eq("R7 gstat bit0", d, 32'h1);
        chk_eq("R7 irq", irq, 1);
        rd(cha(0, 'h10), d); chk_eq("R7 decrement", d, 0);
        wr(12'h018, 32'h1);
        rd(12'h010, d); chk_eq("R8 gstat cleared", d, 0);
        chk_eq("R8 irq low", irq, 0);

        // R9: chain of two on channel 1
        put_desc('h80, 32'hA0, 32'h1043, 0, 32'h81, 0);
        put_desc('hA0, 32'h0, 32'h2043, 0, 32'hA1, 0);
        op_c0_q.delete(); ops0 = op_count;
        wr(cha(1, 'h0), 32'h80);
        wr(cha(1, 'h10), 32'd2);
        repeat (200) @(posedge clk);
        chk_eq("R9 chain ops", op_count - ops0, 2);
        chk_eq("R9 chain second ctrl0", op_c0_q.size() > 1 ? op_c0_q[1] : 32'hX, 32'h2043);
        rd(cha(1, 'h0), d); chk_eq("R9 pointer kept", d, 32'hA0);
        rd(cha(1, 'h10), d); chk_eq("R9 count", d, 0);

        // R9: zero link disarms with count left
        put_desc('hC0, 32'h0, 32'h23, 0, 32'hC1, 0);
        ops0 = op_count;
        wr(cha(2, 'h0), 32'hC0);
        wr(cha(2, 'h10), 32'd3);
        repeat (200) @(posedge clk);
        chk_eq("R9 disarm ops", op_count - ops0, 1);
        rd(cha(2, 'h10), d); chk_eq("R9 disarm count", d, 2);
        wr(12'h018, 32'hF);

        // R5 R6: no-op descriptor on channel 3
        put_desc('h100, 32'h0, 32'h3, 0, 32'h101, 32'h55);
        ops0 = op_count;
        wr(cha(3, 'h0), 32'h100);
        wr(cha(3, 'h10), 32'd1);
        repeat (100) @(posedge clk);
        chk_eq("R5 no op start", op_count - ops0, 0);
        chk_eq("R6 noop status", mem[('h100 >> 2) + 7], 0);
        rd(12'h010, d); chk_eq("R7 gstat bit3", d, 32'h8);
        wr(12'h018, 32'hF);

        // R10: error stall and recovery on channel 3
        put_desc('h140, 32'h0, 32'h22, 0, 32'h141, 32'h77);
        stub_err = 1'b1; stub_code = 8'h2A;
        ops0 = op_count;
        wr(cha(3, 'h0), 32'h140);
        wr(cha(3, 'h10), 32'd1);
        repeat (100) @(posedge clk);
        rd(cha(3, 'h20), d); chk_eq("R10 status code", d, 32'h2A);
        chk_eq("R10 status written", mem[('h140 >> 2) + 7], 32'h2A);
        rd(cha(3, 'h10), d); chk_eq("R10 no decrement", d, 1);
        repeat (100) @(posedge clk);
        chk_eq("R10 stalled", op_count - ops0, 1);
        stub_err = 1'b0; stub_code = 8'h00;
        wr(cha(3, 'h28), 32'hFF);
        repeat (100) @(posedge clk);
        rd(cha(3, 'h20), d); chk_eq("R10 cleared", d, 0);
        chk_eq("R10 rerun", op_count - ops0, 2);
        rd(cha(3, 'h10), d); chk_eq("R10 rerun count", d, 0);

        // R11: disabled channel 0
        fetch_q.delete();
        wr(12'h020, 32'hE);
        wr(cha(0, 'h0), 32'h40);
        wr(cha(0, 'h10), 32'd1);
        repeat (60) @(posedge clk);
        chk_eq("R11 no fetch", fetch_q.size(), 0);
        rd(cha(0, 'h10), d); chk_eq("R11 count held", d, 1);
        wr(12'h020, 32'hF);
        repeat (100) @(posedge clk);
        rd(cha(0, 'h10), d); chk_eq("R11 runs after enable", d, 0);

        // R12: round robin after channel 0 was granted last
        put_desc('h200, 0, 32'h23, 0, 32'd0, 0);
        put_desc('h220, 0, 32'h23, 0, 32'd1, 0);
        put_desc('h240, 0, 32'h23, 0, 32'd2, 0);
        wr(12'h020, 32'h0);
        for (int c = 0; c < 3; c++) begin
            wr(cha(c, 'h0), 32'h200 + 32'h20 * c);
            wr(cha(c, 'h10), 32'd1);
        end
        op_src_q.delete();
        wr(12'h020, 32'hF);
        repeat (300) @(posedge clk);
        chk_eq("R12 grants", op_src_q.size(), 3);
        if (op_src_q.size() == 3) begin
            chk_eq("R12 first", op_src_q[0], 1);
            chk_eq("R12 second", op_src_q[1], 2);
            chk_eq("R12 third", op_src_q[2], 0);
        end

        finish_run();
    end

endmodule